// File: doc/BRIEF.md
# Real-Time Clock Host Bus Port

This block is the host-facing register access port of a real-time clock. One 8-bit bus carries both register addresses and register data. An address/data select input chooses which of the two a transfer carries. A write with the select high loads the internal address register. Every later data transfer, read or write, acts on that address until the host writes a new address.

The port accepts two handshake styles, chosen by a style input. In the first style, separate active-low read and write strobes are qualified by an active-low chip select. In the second style, the read strobe input serves as an active-low data strobe and the write strobe input serves as a direction line. Reads are purely combinational from the pins, so there is never a busy state and no wait is needed. Writes pass through two-flop synchronisers and commit as a single-cycle write-enable pulse in the clock domain. The commit happens when the strobe is released. An active-low power-fail input forces the bus driver off and blocks commits.

Top module: `rtc_hostbus_port`

## Requirements
- R1: After reset, `reg_addr` is 0x00 and `reg_we` is 0.
- R2: A write transfer with `adsel`=1 loads the 8-bit bus value into `reg_addr` and produces no `reg_we` pulse.
- R3: A write transfer with `adsel`=0 produces exactly one `reg_we` pulse. The pulse is one clock wide, high after the third rising clock edge following strobe release, with `reg_wdata` equal to the bus value.
- R4: `reg_addr` keeps its value across any number of data transfers until the next address write.
- R5: With `bus_style`=0, while `cs_n`=0, `rd_n`=0, `adsel`=0 and `pfo_n`=1, `ad_oe` is 1 and `ad_o` equals `reg_rdata`, with no clock delay.
- R6: A read ends, with `ad_oe` returning to 0, as soon as either `cs_n` or `rd_n` goes high.
- R7: With `bus_style`=1, `rd_n` is the data strobe and `wr_n` is the direction: 1 means read and 0 means write. A write commits on release of the data strobe, with the same pulse timing as R3.
- R8: With `bus_style`=1, a low data strobe with `wr_n`=0 never drives the bus.
- R9: While `pfo_n`=0, `ad_oe` is 0 whatever the other inputs are.
- R10: A write whose strobe is released while `pfo_n` is 0 changes neither `reg_addr` nor `reg_wdata` and yields no `reg_we` pulse.
- R11: A read with `adsel`=1 does not drive the bus (`ad_oe`=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_style | input | 1 | 0: separate read/write strobes; 1: data strobe plus direction |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Read strobe (style 0) or data strobe (style 1), active low |
| wr_n | input | 1 | Write strobe (style 0) or direction, 1 = read (style 1) |
| adsel | input | 1 | 1: transfer carries an address; 0: transfer carries data |
| pfo_n | input | 1 | Active-low power-fail status |
| ad_i | input | 8 | Bus value from the host |
| ad_o | output | 8 | Bus value toward the host |
| ad_oe | output | 1 | Bus driver enable |
| reg_addr | output | 8 | Latched register address |
| reg_wdata | output | 8 | Data for the register write |
| reg_we | output | 1 | Single-cycle register write enable |
| reg_rdata | input | 8 | Contents of the addressed register |

## Verification
On every cycle, the embedded properties check four things. The write pulse never lasts longer than one cycle. The address never changes in the same cycle as a data commit or outside the cycle after a strobe window. No commit follows a cycle with synchronised power fail. The bus driver stays off during power fail. Exact timing of the commit pulse, the captured values, persistence of the address over several data phases, and the asynchronous start and end of reads in both handshake styles are only shown by the bench's scenarios. The bench models the register file as a function of the address.

// File: rtl/rtc_hostbus_port.sv
module rtc_hostbus_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_style,
  input  logic         cs_n,
  input  logic         rd_n,
  input  logic         wr_n,
  input  logic         adsel,
  input  logic         pfo_n,
  input  logic [W-1:0] ad_i,
  output logic [W-1:0] ad_o,
  output logic         ad_oe,
  output logic [W-1:0] reg_addr,
  output logic [W-1:0] reg_wdata,
  output logic         reg_we,
  input  logic [W-1:0] reg_rdata
);

  logic [1:0]   cs_q, rd_q, wr_q, sel_q, pf_q;
  logic [W-1:0] ad_q1, ad_q2, cap_d;
  logic         cap_sel, act_d;
  logic         cs_s, rd_s, wr_s, sel_s, pf_s, wr_act_s, rd_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q  <= 2'b11;
      rd_q  <= 2'b11;
      wr_q  <= 2'b11;
      sel_q <= 2'b00;
      pf_q  <= 2'b00;
      ad_q1 <= '0;
      ad_q2 <= '0;
    end else begin
      cs_q  <= {cs_q[0], cs_n};
      rd_q  <= {rd_q[0], rd_n};
      wr_q  <= {wr_q[0], wr_n};
      sel_q <= {sel_q[0], adsel};
      pf_q  <= {pf_q[0], pfo_n};
      ad_q1 <= ad_i;
      ad_q2 <= ad_q1;
    end
  end

  assign cs_s  = cs_q[1];
  assign rd_s  = rd_q[1];
  assign wr_s  = wr_q[1];
  assign sel_s = sel_q[1];
  assign pf_s  = pf_q[1];

  assign wr_act_s = bus_style ? (!cs_s && !rd_s && !wr_s) : (!cs_s && !wr_s);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_d     <= 1'b0;
      cap_d     <= '0;
      cap_sel   <= 1'b0;
      reg_addr  <= '0;
      reg_wdata <= '0;
      reg_we    <= 1'b0;
    end else begin
      act_d  <= wr_act_s;
      reg_we <= 1'b0;
      if (wr_act_s) begin
        cap_d   <= ad_q2;
        cap_sel <= sel_s;
      end
      if (act_d && !wr_act_s && pf_s) begin
        if (cap_sel) reg_addr <= cap_d;
        else begin
          reg_wdata <= cap_d;
          reg_we    <= 1'b1;
        end
      end
    end
  end

  assign rd_act = bus_style ? (!cs_n && !rd_n && wr_n) : (!cs_n && !rd_n);
  assign ad_oe  = pfo_n && rd_act && !adsel;
  assign ad_o   = ad_oe ? reg_rdata : '0;

  p_we_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);

  p_addr_no_we_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> $stable(reg_addr));

  p_addr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(act_d) |-> $stable(reg_addr));

  p_commit_pf_r10: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> $past(pf_s));

  p_oe_pfail_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !pfo_n |-> !ad_oe);

endmodule

// File: tb/rtc_hostbus_port_tb.sv
`timescale 1ns/1ps
module rtc_hostbus_port_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_style = 1'b0, cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, adsel = 1'b0, pfo_n = 1'b1;
  logic [7:0] ad_i = 8'h00, ad_o, reg_addr, reg_wdata, reg_rdata;
  logic ad_oe, reg_we;
  int checks = 0, fails = 0;
  logic [7:0] cur_addr = 8'h00;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  assign reg_rdata = reg_addr ^ 8'h5A;

  rtc_hostbus_port #(.W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_style(bus_style), .cs_n(cs_n), .rd_n(rd_n),
    .wr_n(wr_n), .adsel(adsel), .pfo_n(pfo_n), .ad_i(ad_i), .ad_o(ad_o),
    .ad_oe(ad_oe), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
    .reg_rdata(reg_rdata));

  // style, adsel, value
  localparam logic [9:0] VEC [8] = '{
    {1'b0, 1'b1, 8'h10}, {1'b0, 1'b0, 8'hA5}, {1'b0, 1'b0, 8'h3C}, {1'b1, 1'b1, 8'hFF},
    {1'b1, 1'b0, 8'h00}, {1'b0, 1'b0, 8'hFF}, {1'b1, 1'b1, 8'h00}, {1'b1, 1'b0, 8'h81}};

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  // Write transfer; checks pulse timing, data and address (R2, R3, R4, R7, R10)
  task automatic do_write(input logic sty, input logic sel, input logic [7:0] v, input bit pf_ok);
    logic [7:0] old_w;
    old_w = reg_wdata;
    @(negedge clk);
    bus_style = sty; adsel = sel; ad_i = v; cs_n = 1'b0; wr_n = 1'b0;
    if (sty) rd_n = 1'b0;
    repeat (4) @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1; rd_n = 1'b1;
    ad_i = ~v;
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      if (k == 3 && pf_ok && !sel) begin
        chk(reg_we === 1'b1, "R3/R7 pulse", {7'd0, reg_we}, 8'h01);
        chk(reg_wdata === v, "R3/R7 wdata", reg_wdata, v);
        chk(reg_addr === cur_addr, "R4 addr held", reg_addr, cur_addr);
      end else begin
        chk(reg_we === 1'b0, pf_ok ? (sel ? "R2 no pulse" : "R3 single") : "R10 no pulse",
            {7'd0, reg_we}, 8'h00);
      end
    end
    if (sel && pf_ok) cur_addr = v;
    chk(reg_addr === cur_addr, pf_ok ? "R2 addr" : "R10 addr", reg_addr, cur_addr);
    if (!pf_ok) chk(reg_wdata === old_w, "R10 wdata", reg_wdata, old_w);
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual 00 expected 01");
      finish_run();
    end
  end

  initial begin
    #1;
    repeat (3) @(negedge clk);
    chk(reg_addr === 8'h00, "R1 addr", reg_addr, 8'h00);
    chk(reg_we === 1'b0, "R1 we", {7'd0, reg_we}, 8'h00);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(reg_addr === 8'h00 && reg_we === 1'b0, "R1 after release", reg_addr, 8'h00);

    for (int i = 0; i < 8; i++) begin
      do_write(VEC[i][9], VEC[i][8], VEC[i][7:0], 1'b1);
      @(negedge clk);
      adsel = 1'b0; cs_n = 1'b0; rd_n = 1'b0; wr_n = 1'b1; bus_style = VEC[i][9];
      #1;
      chk(ad_oe === 1'b1, "R5/R7 oe", {7'd0, ad_oe}, 8'h01);
      chk(ad_o === (cur_addr ^ 8'h5A), "R5 data", ad_o, cur_addr ^ 8'h5A);
      cs_n = 1'b1; rd_n = 1'b1;
    end

    // R6: release only rd_n, then only cs_n
    @(negedge clk);
    bus_style = 1'b0; adsel = 1'b0; cs_n = 1'b0; rd_n = 1'b0; #1;
    rd_n = 1'b1; #1;
    chk(ad_oe === 1'b0, "R6 rd release", {7'd0, ad_oe}, 8'h00);
    rd_n = 1'b0; #1;
    chk(ad_oe === 1'b1, "R6 reopen", {7'd0, ad_oe}, 8'h01);
    cs_n = 1'b1; #1;
    chk(ad_oe === 1'b0, "R6 cs release", {7'd0, ad_oe}, 8'h00);
    rd_n = 1'b1;

    // R8: style 1 with direction low is not a read
    bus_style = 1'b1; cs_n = 1'b0; rd_n = 1'b0; wr_n = 1'b0; #1;
    chk(ad_oe === 1'b0, "R8 write dir", {7'd0, ad_oe}, 8'h00);
    cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    repeat (8) @(negedge clk);
    chk(reg_addr === cur_addr, "R8 restore", reg_addr, cur_addr);

    // R11: read during address phase
    bus_style = 1'b0; adsel = 1'b1; cs_n = 1'b0; rd_n = 1'b0; #1;
    chk(ad_oe === 1'b0, "R11 addr read", {7'd0, ad_oe}, 8'h00);
    cs_n = 1'b1; rd_n = 1'b1; adsel = 1'b0;

    // R9: power fail blocks bus driver
    pfo_n = 1'b0; cs_n = 1'b0; rd_n = 1'b0; #1;
    chk(ad_oe === 1'b0, "R9 pfail oe", {7'd0, ad_oe}, 8'h00);
    cs_n = 1'b1; rd_n = 1'b1;

    // R10: writes during power fail are dropped
    do_write(1'b0, 1'b1, 8'h77, 1'b0);
    do_write(1'b1, 1'b0, 8'h66, 1'b0);
    pfo_n = 1'b1;
    repeat (3) @(negedge clk);
    do_write(1'b0, 1'b0, 8'h42, 1'b1);

    done = 1'b1;
    finish_run();
  end
endmodule